// File: doc/BRIEF.md
# Memory Scan Access Arbiter

This block shares a single read port on non-volatile program memory between a CPU's instruction fetches and a background scanner. Once the go bit is set, the block walks the scan address upward from a start address to an end address. In every cycle it decides whether the port belongs to the CPU or to the scanner. When the scanner takes a cycle the CPU would otherwise have used, the block raises a CPU stall. When the last address has been read, it clears go and pulses done.

There are four scheduling modes. Burst mode holds the CPU for the whole scan. Interleaved mode gives the CPU at least one cycle after every scanner read. Trigger-gated mode is interleaved mode that waits for a trigger edge before its first read. Idle-slot mode reads only in cycles when the CPU has no use for the memory. An interrupt-mode bit sets how an active interrupt interacts with the scan in each mode. The consumer of the scanned data and the selection of the trigger source sit outside this block.

Top module: `scan_arbiter`

## Requirements
- R1: During and after a synchronous active-low reset, `go_o`, `scan_rd_o`, `cpu_stall_o` and `done_o` are 0 and `scan_addr_o` is 0.
- R2: A pulse on `go_set_i` while go is clear sets go and loads the start address. Each completed scanner read advances `scan_addr_o` by one. A scan that runs to completion issues exactly end−start+1 reads, in ascending address order.
- R3: In the cycle after the read of the end address, `done_o` is 1 for exactly one cycle and `go_o` is 0.
- R4: In burst mode (`mode_i` = 01), with no interrupt pause, the block reads and stalls the CPU in every cycle from the cycle after go is set until the final read.
- R5: In burst mode, `go_clr_i` has no effect while a scan is running. The scan continues and still ends with done.
- R6: In interleaved mode (`mode_i` = 00), a scanner read is never granted in the cycle right after another scanner read. The CPU is stalled only in cycles that carry a scanner read.
- R7: In trigger-gated mode (`mode_i` = 11), no read happens until `trig_i` has risen while go was already set. A rising edge that arrives in the same cycle go is set does not count. After the first read, the rules of R6 apply.
- R8: In idle-slot mode (`mode_i` = 10), a read happens in every cycle where go is set, no pause is active and `cpu_idle_i` is 1, and in no other cycle. `cpu_stall_o` stays 0.
- R9: With `int_mode_i` = 1, any cycle with `irq_active_i` = 1 has no scanner read and no stall, in every mode. The scan resumes when the interrupt ends.
- R10: With `int_mode_i` = 0, `irq_active_i` has no effect, and the scan keeps the stall and read rules of its mode.
- R11: Outside burst mode, a `go_clr_i` pulse clears go at the next clock edge. No further reads follow and done is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Scheduling mode: 00 interleaved, 01 burst, 10 idle-slot, 11 trigger-gated |
| go_set_i | input | 1 | Software pulse that starts a scan |
| go_clr_i | input | 1 | Software pulse that clears go (ignored in burst mode) |
| int_mode_i | input | 1 | 1: an active interrupt pauses the scan; 0: the scan runs on |
| trig_i | input | 1 | External trigger; its rising edge releases trigger-gated mode |
| cpu_idle_i | input | 1 | CPU needs no memory access this cycle |
| irq_active_i | input | 1 | An interrupt handler is executing |
| start_addr_i | input | AW | First scan address |
| end_addr_i | input | AW | Last scan address (not below start) |
| scan_addr_o | output | AW | Scanner read address |
| scan_rd_o | output | 1 | Scanner owns the memory port this cycle |
| cpu_stall_o | output | 1 | CPU must hold this cycle |
| done_o | output | 1 | One-cycle pulse after the final read |
| go_o | output | 1 | Current go bit |

## Verification
The bench sweeps every mode, both interrupt modes and two scan lengths. It also runs aborts and extra runs at the top of the address range. Each cycle it compares every output against a model written from the requirements. Several corner cases get direct attention.

A trigger edge that lands in the launch cycle, or a trigger held high across launch, must not release trigger-gated mode; a design that counts either edge would start reading cycles early. An interrupt window placed right after a scanner read shows whether the interleave spacing survives a pause. A design that paused without fully dropping the stall would freeze the CPU during the handler. A clear pulse in burst mode, and another late in an interleaved scan, separate an ignored abort from an honoured one. Here a faulty design would either stop a burst early or raise done after an abort.

// File: rtl/scan_arb_pkg.sv
// Package: shared encodings for the memory scan access arbiter.
// Assumes the two-bit mode field is decoded exactly as listed here.
package scan_arb_pkg;

    typedef enum logic [1:0] {
        SCAN_INTERLEAVE = 2'b00,
        SCAN_BURST      = 2'b01,
        SCAN_IDLE_SLOT  = 2'b10,
        SCAN_TRIG_GATED = 2'b11
    } scan_mode_e;

endpackage

// File: rtl/scan_addr_seq.sv
// Module: scan_addr_seq
// Owns the go bit, the scan address and the done pulse. A launch loads the
// start address; every granted read advances the address or, on the end
// address, finishes the scan. Assumes end_addr_i >= start_addr_i and that
// the address inputs are stable while go is set.
module scan_addr_seq #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_set_i,
    input  logic          go_clr_i,
    input  logic          hold_go_i,
    input  logic          grant_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [AW-1:0] end_addr_i,
    output logic          go_o,
    output logic [AW-1:0] addr_o,
    output logic          done_o,
    output logic          launch_o
);

    logic          go_q;
    logic [AW-1:0] addr_q;
    logic          done_q;
    logic          last_addr;

    // A set request only launches a scan when none is running.
    assign launch_o  = go_set_i & ~go_q;
    assign last_addr = (addr_q == end_addr_i);

    // Go bit, address counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q   <= 1'b0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch_o) begin
                go_q   <= 1'b1;
                addr_q <= start_addr_i;
            end else if (go_q) begin
                if (go_clr_i && !hold_go_i) begin
                    go_q <= 1'b0;
                end else if (grant_i) begin
                    if (last_addr) begin
                        go_q   <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        addr_q <= addr_q + AW'(1);
                    end
                end
            end
        end
    end

    assign go_o   = go_q;
    assign addr_o = addr_q;
    assign done_o = done_q;

endmodule

// File: rtl/scan_trig_gate.sv
// Module: scan_trig_gate
// Detects a rising edge of the external trigger and arms the scan once such
// an edge arrives while go is already set. Each launch disarms it. Assumes
// trig_i is already synchronous to clk.
module scan_trig_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic go_i,
    input  logic launch_i,
    output logic armed_o
);

    logic trig_q;
    logic armed_q;
    logic trig_rise;

    assign trig_rise = trig_i & ~trig_q;

    // Previous trigger level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    // Arm flag: cleared at launch, set by an edge seen during a scan.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed_q <= 1'b0;
        else if (launch_i)         armed_q <= 1'b0;
        else if (go_i && trig_rise) armed_q <= 1'b1;
    end

    assign armed_o = armed_q;

endmodule

// File: rtl/scan_slot_grant.sv
// Module: scan_slot_grant
// Per-cycle port arbitration: decides whether the scanner reads this cycle
// and whether the CPU must stall, according to the mode. Keeps a one-bit
// history of the previous grant to space out interleaved reads. Assumes
// paused_i already folds in the interrupt-mode policy.
module scan_slot_grant
    import scan_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  scan_mode_e mode_i,
    input  logic       go_i,
    input  logic       launch_i,
    input  logic       paused_i,
    input  logic       armed_i,
    input  logic       cpu_idle_i,
    output logic       grant_o,
    output logic       stall_o
);

    logic prev_grant_q;
    logic eligible;

    assign eligible = go_i & ~paused_i;

    // Mode-specific grant and stall decision.
    always_comb begin
        grant_o = 1'b0;
        stall_o = 1'b0;
        unique case (mode_i)
            SCAN_BURST: begin
                grant_o = eligible;
                stall_o = eligible;
            end
            SCAN_INTERLEAVE: begin
                grant_o = eligible & ~prev_grant_q;
                stall_o = grant_o;
            end
            SCAN_TRIG_GATED: begin
                grant_o = eligible & armed_i & ~prev_grant_q;
                stall_o = grant_o;
            end
            SCAN_IDLE_SLOT: begin
                grant_o = eligible & cpu_idle_i;
                stall_o = 1'b0;
            end
            default: begin
                grant_o = 1'b0;
                stall_o = 1'b0;
            end
        endcase
    end

    // Remember whether the previous cycle carried a scanner read.
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_grant_q <= 1'b0;
        else if (launch_i) prev_grant_q <= 1'b0;
        else               prev_grant_q <= grant_o;
    end

endmodule

// File: rtl/scan_arbiter.sv
// Module: scan_arbiter (top)
// Schedules background scanner reads of program memory against CPU fetches
// in one of four modes and drives the CPU stall. Assumes all inputs are
// synchronous to clk and the mode is held constant during a scan.
module scan_arbiter
    import scan_arb_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          go_set_i,
    input  logic          go_clr_i,
    input  logic          int_mode_i,
    input  logic          trig_i,
    input  logic          cpu_idle_i,
    input  logic          irq_active_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [AW-1:0] end_addr_i,
    output logic [AW-1:0] scan_addr_o,
    output logic          scan_rd_o,
    output logic          cpu_stall_o,
    output logic          done_o,
    output logic          go_o
);

    scan_mode_e mode;
    logic       go;
    logic       launch;
    logic       armed;
    logic       grant;
    logic       stall;
    logic       paused;

    assign mode   = scan_mode_e'(mode_i);
    // An interrupt suspends the scanner only when the interrupt-mode bit asks for it.
    assign paused = int_mode_i & irq_active_i;

    scan_addr_seq #(.AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_set_i     (go_set_i),
        .go_clr_i     (go_clr_i),
        .hold_go_i    (mode == SCAN_BURST),
        .grant_i      (grant),
        .start_addr_i (start_addr_i),
        .end_addr_i   (end_addr_i),
        .go_o         (go),
        .addr_o       (scan_addr_o),
        .done_o       (done_o),
        .launch_o     (launch)
    );

    scan_trig_gate u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .go_i     (go),
        .launch_i (launch),
        .armed_o  (armed)
    );

    scan_slot_grant u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .go_i       (go),
        .launch_i   (launch),
        .paused_i   (paused),
        .armed_i    (armed),
        .cpu_idle_i (cpu_idle_i),
        .grant_o    (grant),
        .stall_o    (stall)
    );

    assign scan_rd_o   = grant;
    assign cpu_stall_o = stall;
    assign go_o        = go;

endmodule

// File: rtl/scan_arbiter_chk.sv
// Module: scan_arbiter_chk
// Property checker for scan_arbiter, attached by bind. Observes ports only.
module scan_arbiter_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic          go_clr_i,
    input logic          int_mode_i,
    input logic          cpu_idle_i,
    input logic          irq_active_i,
    input logic [AW-1:0] end_addr_i,
    input logic [AW-1:0] scan_addr_o,
    input logic          scan_rd_o,
    input logic          cpu_stall_o,
    input logic          done_o,
    input logic          go_o
);

    logic interleaved;
    assign interleaved = (mode_i == 2'b00) || (mode_i == 2'b11);

    // R1: reset clears the visible state on the next edge.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!go_o && !done_o && !scan_rd_o && !cpu_stall_o));

    // R2: a read that leaves the scan running advances the address by one.
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_rd_o && go_o && scan_addr_o != end_addr_i && !go_clr_i) |=>
        (scan_addr_o == $past(scan_addr_o) + AW'(1)));

    // R3: done lasts one cycle and go is already clear.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_go_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !go_o);

    // R5: a running burst is not ended by anything but its final read.
    p_burst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && go_o && !(scan_rd_o && scan_addr_o == end_addr_i)) |=> go_o);

    // R6: interleaved reads are spaced, and stall only accompanies a read.
    p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (interleaved && scan_rd_o) |=> !scan_rd_o);
    p_stall_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b01 && cpu_stall_o) |-> scan_rd_o);

    // R8: idle-slot mode reads only when the CPU is idle and never stalls.
    p_idle_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |-> (!cpu_stall_o && (!scan_rd_o || cpu_idle_i)));

    // R9: a pausing interrupt removes both read and stall.
    p_irq_pause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode_i && irq_active_i) |-> (!scan_rd_o && !cpu_stall_o));

    // Any read happens only while go is set.
    p_read_needs_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_rd_o |-> go_o);

endmodule

bind scan_arbiter scan_arbiter_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .go_clr_i     (go_clr_i),
    .int_mode_i   (int_mode_i),
    .cpu_idle_i   (cpu_idle_i),
    .irq_active_i (irq_active_i),
    .end_addr_i   (end_addr_i),
    .scan_addr_o  (scan_addr_o),
    .scan_rd_o    (scan_rd_o),
    .cpu_stall_o  (cpu_stall_o),
    .done_o       (done_o),
    .go_o         (go_o)
);

// File: tb/tb_scan_arbiter.sv
// Bench for scan_arbiter: sweeps modes, interrupt modes and lengths, and
// compares each cycle to a reference model built from the requirements.
module tb_scan_arbiter;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic          go_set_i = 1'b0;
    logic          go_clr_i = 1'b0;
    logic          int_mode_i = 1'b0;
    logic          trig_i = 1'b0;
    logic          cpu_idle_i = 1'b0;
    logic          irq_active_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [AW-1:0] end_addr_i = '0;
    logic [AW-1:0] scan_addr_o;
    logic          scan_rd_o;
    logic          cpu_stall_o;
    logic          done_o;
    logic          go_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int reads_seen;

    // Reference model state.
    logic          m_go = 1'b0;
    logic          m_last = 1'b0;
    logic          m_armed = 1'b0;
    logic          m_done = 1'b0;
    logic          m_ptrig = 1'b0;
    logic [AW-1:0] m_addr = '0;

    always #2 clk = ~clk;

    scan_arbiter #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .go_set_i(go_set_i),
        .go_clr_i(go_clr_i), .int_mode_i(int_mode_i), .trig_i(trig_i),
        .cpu_idle_i(cpu_idle_i), .irq_active_i(irq_active_i),
        .start_addr_i(start_addr_i), .end_addr_i(end_addr_i),
        .scan_addr_o(scan_addr_o), .scan_rd_o(scan_rd_o),
        .cpu_stall_o(cpu_stall_o), .done_o(done_o), .go_o(go_o)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            finish_run();
        end
    end

    // One cycle: drive inputs, compare outputs with the model, advance the model.
    task automatic cyc(input logic [1:0] md, input logic im, input logic set,
                       input logic clr, input logic trg, input logic idle,
                       input logic irq);
        logic paused, e_rd, e_st, rise;
        logic n_go, n_last, n_armed, n_done;
        logic [AW-1:0] n_addr;
        string tag;
        mode_i = md; int_mode_i = im; go_set_i = set; go_clr_i = clr;
        trig_i = trg; cpu_idle_i = idle; irq_active_i = irq;
        #1;
        paused = im & irq;
        e_st = 1'b0;
        case (md)
            2'b01:   begin e_rd = m_go & ~paused; e_st = e_rd; end
            2'b00:   begin e_rd = m_go & ~paused & ~m_last; e_st = e_rd; end
            2'b11:   begin e_rd = m_go & ~paused & ~m_last & m_armed; e_st = e_rd; end
            default: begin e_rd = m_go & ~paused & idle; end
        endcase
        case (md)
            2'b01:   tag = "R4";
            2'b00:   tag = "R6";
            2'b11:   tag = "R7";
            default: tag = "R8";
        endcase
        if (irq && m_go) tag = im ? "R9" : "R10";
        check(scan_rd_o == e_rd, tag, "scan_rd", int'(scan_rd_o), int'(e_rd));
        check(cpu_stall_o == e_st, tag, "cpu_stall", int'(cpu_stall_o), int'(e_st));
        if (e_rd) begin
            check(scan_addr_o == m_addr, "R2", "scan_addr", int'(scan_addr_o), int'(m_addr));
            reads_seen++;
        end
        check(done_o == m_done, "R3", "done", int'(done_o), int'(m_done));
        check(go_o == m_go, (clr && md == 2'b01) ? "R5" : "R11", "go", int'(go_o), int'(m_go));
        rise = trg & ~m_ptrig;
        n_go = m_go; n_addr = m_addr; n_armed = m_armed; n_done = 1'b0; n_last = e_rd;
        if (set && !m_go) begin
            n_go = 1'b1; n_addr = start_addr_i; n_armed = 1'b0; n_last = 1'b0;
        end else if (m_go) begin
            if (rise) n_armed = 1'b1;
            if (clr && md != 2'b01) n_go = 1'b0;
            else if (e_rd) begin
                if (m_addr == end_addr_i) begin n_go = 1'b0; n_done = 1'b1; end
                else n_addr = m_addr + AW'(1);
            end
        end
        m_go = n_go; m_addr = n_addr; m_armed = n_armed; m_done = n_done;
        m_last = n_last; m_ptrig = trg;
        @(negedge clk);
    endtask

    // One scenario: launch in cycle 0, optional clear at clr_at, fixed stimulus patterns.
    task automatic scenario(input logic [1:0] md, input logic im,
                            input logic [AW-1:0] sa, input int len, input int clr_at);
        start_addr_i = sa;
        end_addr_i   = sa + AW'(len - 1);
        reads_seen   = 0;
        for (int c = 0; c < 48; c++) begin
            cyc(md, im, c == 0, c == clr_at, (c < 2) || (c >= 6 && c < 8),
                (c % 3) != 1, (c == 3) || (c == 4));
        end
        if (clr_at < 0 || md == 2'b01)
            check(reads_seen == len, "R2", "read count", reads_seen, len);
        check(go_o == 1'b0, "R3", "go after scan", int'(go_o), 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        check(go_o == 1'b0 && done_o == 1'b0, "R1", "go/done in reset", int'({go_o, done_o}), 0);
        check(scan_rd_o == 1'b0 && cpu_stall_o == 1'b0, "R1", "rd/stall in reset",
              int'({scan_rd_o, cpu_stall_o}), 0);
        check(scan_addr_o == '0, "R1", "addr in reset", int'(scan_addr_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int md = 0; md < 4; md++)
            for (int im = 0; im < 2; im++)
                for (int ln = 1; ln <= 4; ln += 3)
                    scenario(2'(md), 1'(im), 16'h0120 + 16'(md * 16), ln, -1);
        // R2: scan at the top of the address space.
        scenario(2'b00, 1'b0, 16'hFFFD, 3, -1);
        scenario(2'b01, 1'b1, 16'hFFFE, 2, -1);
        // R5: clear during a burst is ignored.
        scenario(2'b01, 1'b0, 16'h0200, 6, 2);
        // R11: clear aborts interleaved and trigger-gated scans without done.
        scenario(2'b00, 1'b0, 16'h0300, 8, 5);
        scenario(2'b11, 1'b0, 16'h0400, 4, 9);
        scenario(2'b10, 1'b0, 16'h0500, 8, 6);
        finish_run();
    end

endmodule